// File: doc/BRIEF.md
# Dual-Lane Threshold Event Capture

This block takes two 8-bit sample lanes. One lane is sampled on the rising edge of the sampling clock and the other on the falling edge. Each system clock cycle the block receives one pair from the two lanes. It treats the pair as two consecutive points of a single stream at twice the clock rate, with the rising-lane sample first. Every sample in that stream is compared with a threshold that software may rewrite at any time.

When a sample reaches the threshold, the block freezes a snapshot. The snapshot holds a programmable number of earlier samples, the crossing sample itself, and a fixed number of later samples. The block then frames the snapshot as one header word followed by one word per sample and writes it to an output FIFO. The header carries a half-sample-resolution timestamp and the sample count. The timestamp comes from a free-running cycle counter that an external command can clear.

A downstream packet builder drains the FIFO through a show-ahead read port. A snapshot that would not fit entirely into the FIFO is discarded as a whole and counted.

Top module: `evcap_top`

## Requirements
- R1: Within a cycle the sample on `lane_rise` precedes the sample on `lane_fall` in the merged stream, and stored samples appear in stream order.
- R2: While armed, a sample whose unsigned value is greater than or equal to the threshold starts an event. If both samples of a pair qualify, the rising-lane sample is the crossing.
- R3: A threshold write changes the comparison only for pairs presented in later cycles. The pair presented in the cycle of the write is compared with the old value.
- R4: An event holds P earlier samples, the crossing sample and POST_N later samples, in that order. P (0..15) is the history-depth register value at the crossing.
- R5: Every word is 25 bits. In a header, bit 24 = 1, bits 23:8 hold the timestamp and bits 7:0 hold the sample count P+1+POST_N. In a sample word, bit 24 = 0, bits 23:8 = 0 and bits 7:0 hold the sample.
- R6: Timestamp bits 15:1 hold the cycle counter value of the crossing cycle, and bit 0 is 0 for a rising-lane crossing and 1 for a falling-lane crossing. The counter is 0 in the first cycle after reset and in the cycle after a `ts_clr` cycle, and it increments by one in every other cycle.
- R7: No new crossing is accepted from the crossing cycle until the cycle after the last word of that event has been handled (written or dropped).
- R8: When the event is complete, the block compares the free FIFO space with the event's word count. If there are fewer free entries than words, no word is written and `ovf_count` increments by one.
- R9: `rd_valid` is high whenever the FIFO is non-empty, and `rd_data` then shows the oldest word. `rd_en` with `rd_valid` removes that word at the clock edge.
- R10: After reset the FIFO is empty, `ovf_count` is 0, the threshold is 0xFF and the history depth is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one sample pair per cycle |
| rst | input | 1 | Synchronous active-high reset |
| lane_rise | input | 8 | Sample taken on the rising sampling edge |
| lane_fall | input | 8 | Sample taken on the falling sampling edge |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 8 | New threshold |
| pre_we | input | 1 | History-depth write strobe |
| pre_wdata | input | 4 | New history depth (0..15) |
| ts_clr | input | 1 | Clears the cycle counter for the next cycle |
| rd_en | input | 1 | Pops the FIFO head |
| rd_valid | output | 1 | FIFO head is valid |
| rd_data | output | 25 | FIFO head word |
| ovf_count | output | 16 | Number of dropped events |

## Verification
The bench targets the cases where the lane order matters. A crossing on the falling lane alone must give an odd timestamp, and a crossing on both lanes at once must report the rising lane. A design that swapped the lanes would produce wrong timestamp LSBs and reversed sample pairs. History depths of 0 and 15 expose off-by-one errors in the history tap indexing, which would show up as a shifted or wrong-length snapshot. A threshold written in the same cycle as a qualifying sample catches a comparator that uses the new value too early. Extra crossings during the tail and the flush, and a third event written into a nearly full FIFO, catch a design that retriggers, writes partial events, or forgets to count a drop.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
    localparam int SW  = 8;
    localparam int TSW = 16;
    localparam int CW  = 8;

    typedef logic [SW-1:0] smp_t;

    typedef struct packed {
        logic           is_hdr;
        logic [TSW-1:0] stamp;
        logic [CW-1:0]  low;
    } word_t;

    typedef enum logic [1:0] {ST_ARMED, ST_TAIL, ST_FLUSH} cap_st_e;

    function automatic word_t hdr_word(input logic [TSW-1:0] s, input logic [CW-1:0] n);
        word_t w;
        w.is_hdr = 1'b1;
        w.stamp  = s;
        w.low    = n;
        return w;
    endfunction

    function automatic word_t dat_word(input smp_t v);
        word_t w;
        w        = '0;
        w.low    = CW'(v);
        return w;
    endfunction
endpackage

// File: rtl/evcap_hist.sv
module evcap_hist
    import evcap_pkg::*;
#(
    parameter int DEPTH = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  smp_t                first_i,
    input  smp_t                second_i,
    output logic [DEPTH*SW-1:0] taps_o
);
    smp_t r [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        if (g == 0) begin : g_new2
            always_ff @(posedge clk) r[g] <= rst ? '0 : second_i;
        end else if (g == 1) begin : g_new1
            always_ff @(posedge clk) r[g] <= rst ? '0 : first_i;
        end else begin : g_old
            always_ff @(posedge clk) r[g] <= rst ? '0 : r[g-2];
        end
        assign taps_o[g*SW +: SW] = r[g];
    end
endmodule

// File: rtl/evcap_detect.sv
module evcap_detect
    import evcap_pkg::*;
(
    input  smp_t first_i,
    input  smp_t second_i,
    input  smp_t thr_i,
    input  logic armed_i,
    output logic fire_o,
    output logic second_o
);
    logic hit1, hit2;
    always_comb begin
        hit1     = first_i  >= thr_i;
        hit2     = second_i >= thr_i;
        fire_o   = armed_i && (hit1 || hit2);
        second_o = !hit1;
    end
endmodule

// File: rtl/evcap_fifo.sv
module evcap_fifo #(
    parameter int DW    = 25,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CNTW = AW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic            rd_i,
    output logic [DW-1:0]   rdata_o,
    output logic            empty_o,
    output logic [CNTW-1:0] count_o
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (wr_i) mem[wp] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
            count_o <= '0;
        end else begin
            if (wr_i) wp <= wp + 1'b1;
            if (rd_i) rp <= rp + 1'b1;
            count_o <= count_o + CNTW'(wr_i) - CNTW'(rd_i);
        end
    end

    assign rdata_o = mem[rp];
    assign empty_o = (count_o == '0);

    AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst) wr_i |-> (int'(count_o) < DEPTH)); // R8
    AST_FIFO_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst) rd_i |-> !empty_o); // R9
    AST_FIFO_GROWS: assert property (@(posedge clk) disable iff (rst) (wr_i && !rd_i) |=> count_o == $past(count_o) + 1'b1); // R9
endmodule

// File: rtl/evcap_top.sv
module evcap_top
    import evcap_pkg::*;
#(
    parameter int POST_N     = 8,
    parameter int PRE_W      = 4,
    parameter int FIFO_DEPTH = 64,
    parameter int OVF_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       lane_rise,
    input  logic [7:0]       lane_fall,
    input  logic             thr_we,
    input  logic [7:0]       thr_wdata,
    input  logic             pre_we,
    input  logic [PRE_W-1:0] pre_wdata,
    input  logic             ts_clr,
    input  logic             rd_en,
    output logic             rd_valid,
    output logic [24:0]      rd_data,
    output logic [OVF_W-1:0] ovf_count
);
    localparam int PRE_MAX = (1 << PRE_W) - 1;
    localparam int HIST_D  = PRE_MAX;
    localparam int EV_MAX  = PRE_MAX + 1 + POST_N;
    localparam int WW      = $bits(word_t);
    localparam int FC_W    = $clog2(FIFO_DEPTH) + 1;
    localparam int IX_W    = $clog2(EV_MAX + 2) + 1;

    smp_t              thr_q;
    logic [PRE_W-1:0]  pre_q;
    logic [TSW-2:0]    cyc_q;
    cap_st_e           st;
    logic [IX_W-1:0]   fill, n_q, widx;
    smp_t              ev [EV_MAX];
    logic [TSW-1:0]    stamp_q;
    logic [OVF_W-1:0]  ovf_q;

    logic [HIST_D*SW-1:0] taps;
    smp_t              xw [HIST_D+2];
    logic              fire, on_second, room, fifo_wr, fifo_empty;
    logic [FC_W-1:0]   fcount;
    word_t             wr_word;
    logic [WW-1:0]     head;

    evcap_hist #(.DEPTH(HIST_D)) u_hist (
        .clk(clk), .rst(rst), .first_i(lane_rise), .second_i(lane_fall), .taps_o(taps)
    );

    evcap_detect u_det (
        .first_i(lane_rise), .second_i(lane_fall), .thr_i(thr_q),
        .armed_i(st == ST_ARMED), .fire_o(fire), .second_o(on_second)
    );

    always_comb begin
        xw[0] = lane_fall;
        xw[1] = lane_rise;
        for (int i = 0; i < HIST_D; i++) xw[i+2] = taps[i*SW +: SW];
    end

    always_comb begin
        room    = (FIFO_DEPTH - int'(fcount)) >= (int'(n_q) + 1);
        fifo_wr = 1'b0;
        wr_word = '0;
        if (st == ST_FLUSH) begin
            if (widx == '0) begin
                fifo_wr = room;
                wr_word = hdr_word(stamp_q, CW'(n_q));
            end else begin
                fifo_wr = 1'b1;
                wr_word = dat_word(ev[int'(widx) - 1]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q   <= 8'hFF;
            pre_q   <= '0;
            cyc_q   <= '0;
            st      <= ST_ARMED;
            fill    <= '0;
            n_q     <= '0;
            widx    <= '0;
            stamp_q <= '0;
            ovf_q   <= '0;
            for (int j = 0; j < EV_MAX; j++) ev[j] <= '0;
        end else begin
            if (thr_we) thr_q <= thr_wdata;
            if (pre_we) pre_q <= pre_wdata;
            cyc_q <= ts_clr ? '0 : cyc_q + 1'b1;
            case (st)
                ST_ARMED: if (fire) begin
                    for (int j = 0; j <= PRE_MAX; j++) begin
                        if (j <= int'(pre_q))
                            ev[j] <= xw[(on_second ? 0 : 1) + int'(pre_q) - j];
                    end
                    if (!on_second) ev[int'(pre_q) + 1] <= lane_fall;
                    n_q     <= IX_W'(pre_q) + IX_W'(POST_N + 1);
                    fill    <= IX_W'(pre_q) + IX_W'(on_second ? 1 : 2);
                    stamp_q <= {cyc_q, on_second};
                    widx    <= '0;
                    st      <= ((on_second ? 0 : 1) >= POST_N) ? ST_FLUSH : ST_TAIL;
                end
                ST_TAIL: begin
                    if (fill < n_q) ev[int'(fill)] <= lane_rise;
                    if (fill + 1'b1 < n_q) ev[int'(fill) + 1] <= lane_fall;
                    fill <= fill + IX_W'(2);
                    if (fill + IX_W'(2) >= n_q) st <= ST_FLUSH;
                end
                ST_FLUSH: begin
                    if (widx == '0) begin
                        if (room) widx <= IX_W'(1);
                        else begin
                            ovf_q <= ovf_q + 1'b1;
                            st    <= ST_ARMED;
                        end
                    end else if (widx == n_q) st <= ST_ARMED;
                    else widx <= widx + 1'b1;
                end
                default: st <= ST_ARMED;
            endcase
        end
    end

    evcap_fifo #(.DW(WW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr_i(fifo_wr), .wdata_i(wr_word),
        .rd_i(rd_en && !fifo_empty), .rdata_o(head), .empty_o(fifo_empty), .count_o(fcount)
    );

    assign rd_valid  = !fifo_empty;
    assign rd_data   = head;
    assign ovf_count = ovf_q;

    AST_THR_HOLD: assert property (@(posedge clk) disable iff (rst) !thr_we |=> $stable(thr_q)); // R3
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst) (st != ST_ARMED) |=> $stable(stamp_q)); // R7
    AST_OVF_STEP: assert property (@(posedge clk) disable iff (rst) (ovf_q != $past(ovf_q)) |-> (ovf_q == $past(ovf_q) + 1'b1)); // R8
    AST_TS_CLEAR: assert property (@(posedge clk) disable iff (rst) $past(ts_clr) |-> (cyc_q == '0)); // R6
    AST_NO_WRITE_ARMED: assert property (@(posedge clk) disable iff (rst) (st == ST_ARMED) |-> !fifo_wr); // R8
endmodule

// File: tb/sim_evcap_top.sv
module sim_evcap_top;
    localparam int POST = 8;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [7:0]  lr = '0, lf = '0, twd = '0;
    logic        twe = 1'b0, pwe = 1'b0, tclr = 1'b0, rd_en = 1'b0;
    logic [3:0]  pwd = '0;
    logic        rd_valid;
    logic [24:0] rd_data;
    logic [15:0] ovf;

    evcap_top u0 (
        .clk(clk), .rst(rst), .lane_rise(lr), .lane_fall(lf),
        .thr_we(twe), .thr_wdata(twd), .pre_we(pwe), .pre_wdata(pwd),
        .ts_clr(tclr), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .ovf_count(ovf)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int          hist[$];
    logic [24:0] mq[$];
    logic [24:0] got[$];
    int m_thr, m_pre, m_cyc, m_mode, m_ovf, ek, eP, eN, didx;
    logic [15:0] ets;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete(); hist.delete();
            for (int i = 0; i < 16; i++) hist.push_back(0);
            m_thr = 255; m_pre = 0; m_cyc = 0; m_mode = 0; m_ovf = 0; didx = 0;
        end else begin
            int sz, L, a, b;
            sz = mq.size();
            if (rd_en && rd_valid) got.push_back(rd_data);
            if (rd_en && sz > 0) void'(mq.pop_front());
            a = int'(lr); b = int'(lf);
            hist.push_back(a); hist.push_back(b);
            L = hist.size();
            case (m_mode)
                0: if (a >= m_thr || b >= m_thr) begin
                    ek  = (a >= m_thr) ? L - 2 : L - 1;
                    eP  = m_pre;
                    eN  = eP + 1 + POST;
                    ets = {15'(m_cyc), (a >= m_thr) ? 1'b0 : 1'b1};
                    didx = 0;
                    m_mode = (L - 1 >= ek + POST) ? 2 : 1;
                end
                1: if (L - 1 >= ek + POST) m_mode = 2;
                default: begin
                    if (didx == 0) begin
                        if (DEPTH - sz >= eN + 1) begin
                            mq.push_back({1'b1, ets, 8'(eN)});
                            didx = 1;
                        end else begin
                            m_ovf++; m_mode = 0;
                        end
                    end else begin
                        mq.push_back({9'b0, 8'(hist[ek - eP + didx - 1])});
                        if (didx == eN) m_mode = 0; else didx++;
                    end
                end
            endcase
            if (twe) m_thr = int'(twd);
            if (pwe) m_pre = int'(pwd);
            m_cyc = tclr ? 0 : (m_cyc + 1) % 32768;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(rd_valid == (mq.size() > 0), "R9", "rd_valid", rd_valid, mq.size() > 0);
            if (rd_valid && mq.size() > 0)
                chk(rd_data == mq[0], mq[0][24] ? "R5" : "R4", "rd_data", rd_data, mq[0]);
            chk(ovf == 16'(m_ovf), "R8", "ovf_count", ovf, m_ovf);
        end
    end

    int bg = 0;
    task automatic put(input logic [7:0] a, input logic [7:0] b,
                       input bit tw = 0, input logic [7:0] tv = 0,
                       input bit pw = 0, input logic [3:0] pv = 0, input bit clr = 0);
        @(negedge clk);
        lr = a; lf = b; twe = tw; twd = tv; pwe = pw; pwd = pv; tclr = clr;
    endtask

    task automatic quiet(input int n, input int lim);
        for (int i = 0; i < n; i++) begin
            bg++;
            put(8'(bg % lim), 8'((bg * 3) % lim));
        end
    endtask

    task automatic drain(input int lim);
        rd_en = 1'b1;
        while (mq.size() > 0 || m_mode != 0) quiet(1, lim);
        quiet(2, lim);
        rd_en = 1'b0;
    endtask

    function automatic int n_hdr();
        int c = 0;
        foreach (got[i]) if (got[i][24]) c++;
        return c;
    endfunction

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R10", "empty after reset", rd_valid, 0);
        chk(ovf == 16'd0, "R10", "ovf after reset", ovf, 0);
        quiet(5, 250);
        chk(rd_valid == 1'b0, "R10", "default threshold quiet", rd_valid, 0);

        // R2 R4 R6 R1: rising-lane crossing, history 4
        put(0, 0, 1, 8'd100, 1, 4'd4);
        quiet(20, 50);
        got.delete();
        put(10, 10, 0, 0, 0, 0, 1);
        quiet(5, 50);
        put(120, 20);
        quiet(20, 50);
        drain(50);
        chk(n_hdr() == 1, "R2", "headers", n_hdr(), 1);
        chk(got[0][23:8] == 16'd10, "R6", "stamp rise", got[0][23:8], 10);
        chk(got[0][7:0] == 8'd13, "R4", "count pre4", got[0][7:0], 13);
        chk(got[5][7:0] == 8'd120, "R4", "crossing slot", got[5][7:0], 120);
        chk(got[6][7:0] == 8'd20, "R1", "fall after rise", got[6][7:0], 20);

        // R6 R4: falling-lane crossing, history 0
        put(0, 0, 0, 0, 1, 4'd0);
        got.delete();
        put(1, 1, 0, 0, 0, 0, 1);
        quiet(3, 50);
        put(30, 140);
        quiet(20, 50);
        drain(50);
        chk(got[0][23:8] == 16'd7, "R6", "stamp fall", got[0][23:8], 7);
        chk(got[0][7:0] == 8'd9, "R4", "count pre0", got[0][7:0], 9);
        chk(got[1][7:0] == 8'd140, "R4", "pre0 first word", got[1][7:0], 140);

        // R1: both lanes cross
        got.delete();
        put(1, 1, 0, 0, 0, 0, 1);
        quiet(2, 50);
        put(130, 140);
        quiet(20, 50);
        drain(50);
        chk(got[0][23:8] == 16'd4, "R1", "both lanes pick rise", got[0][23:8], 4);
        chk(got[2][7:0] == 8'd140, "R1", "second lane follows", got[2][7:0], 140);

        // R3: threshold written in the same cycle as a qualifying sample
        put(0, 0, 1, 8'd200, 1, 4'd2);
        quiet(10, 40);
        got.delete();
        put(1, 1, 0, 0, 0, 0, 1);
        quiet(1, 40);
        put(60, 60, 1, 8'd50);
        put(60, 10);
        quiet(20, 40);
        drain(40);
        chk(n_hdr() == 1, "R3", "one event", n_hdr(), 1);
        chk(got[0][23:8] == 16'd4, "R3", "new threshold next cycle", got[0][23:8], 4);
        put(0, 0, 1, 8'd100, 1, 4'd1);

        // R7: crossings during tail and flush are ignored
        quiet(10, 50);
        got.delete();
        put(150, 5);
        quiet(2, 50);
        put(160, 160);
        quiet(3, 50);
        put(170, 170);
        quiet(30, 50);
        drain(50);
        chk(n_hdr() == 1, "R7", "no retrigger", n_hdr(), 1);
        put(180, 5);
        quiet(30, 50);
        drain(50);
        chk(n_hdr() == 2, "R7", "rearmed", n_hdr(), 2);

        // R4: deepest history
        put(0, 0, 0, 0, 1, 4'd15);
        quiet(20, 50);
        got.delete();
        put(5, 200);
        quiet(30, 50);
        drain(50);
        chk(got[0][7:0] == 8'd24, "R4", "count pre15", got[0][7:0], 24);
        chk(got[16][7:0] == 8'd200, "R4", "pre15 crossing slot", got[16][7:0], 200);

        // R8: third event does not fit
        got.delete();
        for (int k = 0; k < 3; k++) begin
            put(210, 3);
            quiet(45, 50);
        end
        chk(ovf == 16'd1, "R8", "drop counted", ovf, 1);
        drain(50);
        chk(n_hdr() == 2, "R8", "only whole events", n_hdr(), 2);
        chk(got.size() == 50, "R8", "word total", got.size(), 50);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule